// File: doc/BRIEF.md
# Three-Channel Capture/Compare Timer

This block is a 16-bit up-counting timer whose clock passes through a power-of-two prescaler, with three channels that share the counter. Each channel either stores the counter value when its input pin shows a selected edge, or drives its output pin from a comparison against a stored value. The output can stay frozen, be set, be cleared or toggle on a match, or follow the counter in edge-aligned PWM of either polarity. A one-pulse option stops the counter at its first overflow, so one PWM period gives a single pulse.

Software reaches every register through one synchronous bus. A write lands on the clock edge where `bus_we` is high. Read data is registered: it shows the register at `bus_addr` one cycle later. The prescaler code, the reload limit and each compare value have a written copy and a working copy. A per-register buffering bit decides whether a write reaches the working copy at once or only at the next update event. Update, per-channel capture/compare and overcapture events raise sticky flags. The interrupt line is the OR of the enabled flags.

Top module: `cc_timer`

Register addresses: 0 control (bit0 run, bit1 reload buffering, bit2 one-pulse); 1 event (bit0 forces an update); 2 prescaler code [3:0]; 3 reload limit; 4 counter; 5 interrupt enables [3:0]; 6 flags, write 1 to clear; 8..10 channel configuration; 12..14 channel capture/compare value.

Channel configuration fields: [2:0] output mode (0 frozen, 1 set on match, 2 clear on match, 3 toggle on match, 4 PWM high below the compare value, 5 PWM low below it; 6 and 7 act as frozen); [3] compare buffering; [4] capture mode; [5] falling-edge capture; [7:6] capture divider code.

Flag bits: [0] update; [3:1] channel 0..2 capture/compare; [6:4] channel 0..2 overcapture.

## Requirements
- R1: After reset the counter, prescaler code, flags, interrupt enables and compare values read as zero, the reload limit reads 16'hFFFF, every channel output is 0 and `irq` is 0.
- R2: While the run bit (control bit0) is set, the counter advances by one every 2^N clocks, where N is the active prescaler code (0..15). While the run bit is clear, the counter holds its value.
- R3: When the counter advances while at or above the active reload limit, it goes to zero instead. This overflow is an update event and sets flag bit0.
- R4: A write to the prescaler code (address 2) reaches the active code only at the next update event. Reads of address 2 return the active code.
- R5: With reload buffering (control bit1) or a channel's compare buffering (configuration bit3) set, a written value reaches the working copy only at an update event. With the bit clear, it takes effect at once. Reads of addresses 3 and 12..14 return the working copy.
- R6: Writing 1 to event bit0 clears the counter and the prescaler phase, loads all buffered values and sets flag bit0.
- R7: In PWM mode 4 the output is 1 while the counter is below the compare value; mode 5 is the inverse. A compare value above the reload limit keeps a mode-4 output at 1 for the whole period.
- R8: When the counter advances to a channel's compare value in output mode, that channel's flag (bit 1+ch) is set. Modes 1, 2 and 3 then set, clear or toggle the output, and mode 0 leaves it unchanged.
- R9: With one-pulse (control bit2) set, the overflow clears the run bit and the counter stops at zero. A mode-5 channel then gives exactly one pulse, from the compare value through the reload limit.
- R10: In capture mode, a selected edge on the channel pin (rising, or falling when bit5 is set) latches the counter into the channel value and sets flag bit 1+ch. The pin passes through two synchroniser flops first. Bus writes to the value are ignored in this mode.
- R11: The capture divider code D (configuration [7:6]) makes a capture happen on every 2^D-th selected edge, that is every 1st, 2nd, 4th or 8th edge, counted from entry into capture mode.
- R12: A capture while flag bit 1+ch is still set also sets overcapture flag bit 4+ch. The value holds the newest capture.
- R13: `irq` is high exactly when some flag in bits [3:0] is set with its enable bit. Writing 1 to a flag bit clears it and writing 0 leaves it unchanged; a new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the previous cycle's address |
| ch_in | input | 3 | Capture pins, one per channel |
| ch_out | output | 3 | Compare/PWM outputs, one per channel |
| irq | output | 1 | Interrupt request |

## Verification
The bench measures counts over a random run length and prescaler code. A design that ticked once too early, or failed to reset the prescaler phase on a forced update, would be off by one count. It measures PWM duty over whole periods at compare values of zero, just past the reload limit and in between; a design that compared with the wrong inequality would give one cycle too many or too few per period. Buffered reload, compare and prescaler writes are read back before and after an update, which exposes a value that leaks through early. Capture is tested with the wrong polarity, with divided edges and with a second edge before the flag is cleared, where a broken design captures on every edge or overwrites without reporting overcapture.

// File: rtl/cc_timer_pkg.sv
package cc_timer_pkg;

  typedef enum logic [2:0] {
    OC_FROZEN  = 3'd0,
    OC_SET     = 3'd1,
    OC_CLR     = 3'd2,
    OC_TOGGLE  = 3'd3,
    OC_PWM_LO  = 3'd4,
    OC_PWM_HI  = 3'd5
  } oc_mode_e;

  typedef struct packed {
    logic [1:0] cap_div;
    logic       cap_fall;
    logic       cap_sel;
    logic       pre_en;
    oc_mode_e   mode;
  } ch_cfg_t;

  localparam int CFG_W = 8;

  localparam int ADDR_CTRL  = 0;
  localparam int ADDR_EVGEN = 1;
  localparam int ADDR_PSC   = 2;
  localparam int ADDR_ARR   = 3;
  localparam int ADDR_CNT   = 4;
  localparam int ADDR_IEN   = 5;
  localparam int ADDR_STAT  = 6;
  localparam int ADDR_CFG0  = 8;
  localparam int ADDR_CCR0  = 12;

endpackage

// File: rtl/cct_timebase.sv
module cct_timebase #(
  parameter int CW = 16,
  parameter int PW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ug,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic [CW-1:0] arr_act,
  input  logic [PW-1:0] psc_pre,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt,
  output logic [PW-1:0] psc_act,
  output logic          step,
  output logic          ovf,
  output logic          uev
);

  localparam int DW = (1 << PW) - 1;

  logic [DW-1:0] pcnt_q, pcnt_d, lim;
  logic [CW-1:0] cnt_d;
  logic [PW-1:0] psc_d;
  logic          tick, wrap;

  // next state
  always_comb begin
    lim     = DW'((64'd1 << psc_act) - 64'd1);
    tick    = run & (pcnt_q == lim);
    wrap    = tick & (cnt_q >= arr_act);
    cnt_nxt = wrap ? '0 : cnt_q + 1'b1;
    step    = tick & ~ug & ~cnt_we;
    ovf     = wrap & ~ug & ~cnt_we;
    uev     = ug | ovf;

    pcnt_d = pcnt_q;
    if (ug)       pcnt_d = '0;
    else if (run) pcnt_d = tick ? '0 : pcnt_q + 1'b1;

    cnt_d = cnt_q;
    if (ug)          cnt_d = '0;
    else if (cnt_we) cnt_d = cnt_wdata;
    else if (tick)   cnt_d = cnt_nxt;

    psc_d = uev ? psc_pre : psc_act;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q  <= '0;
      cnt_q   <= '0;
      psc_act <= '0;
    end else begin
      pcnt_q  <= pcnt_d;
      cnt_q   <= cnt_d;
      psc_act <= psc_d;
    end
  end

endmodule

// File: rtl/cct_channel.sv
module cct_channel
  import cc_timer_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ch_cfg_t       cfg,
  input  logic          ccr_we,
  input  logic [CW-1:0] ccr_wdata,
  input  logic          uev,
  input  logic          step,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] cnt_nxt,
  input  logic          pin,
  output logic [CW-1:0] ccr_act,
  output logic          out,
  output logic          cmp_evt,
  output logic          cap_evt
);

  logic          pin_s1_q, pin_s2_q, pin_d_q;
  logic [2:0]    ecnt_q, ecnt_d, div_lim;
  logic [CW-1:0] ccr_pre_q, ccr_pre_d, ccr_act_q, ccr_act_d;
  logic          oc_q, oc_d, edge_seen, below;

  assign ccr_act = ccr_act_q;

  // next state
  always_comb begin
    edge_seen = cfg.cap_sel &
                (cfg.cap_fall ? (pin_d_q & ~pin_s2_q) : (pin_s2_q & ~pin_d_q));
    div_lim   = 3'((4'd1 << cfg.cap_div) - 4'd1);
    cap_evt   = edge_seen & (ecnt_q == div_lim);

    ecnt_d = ecnt_q;
    if (!cfg.cap_sel)   ecnt_d = '0;
    else if (edge_seen) ecnt_d = cap_evt ? '0 : ecnt_q + 1'b1;

    cmp_evt = ~cfg.cap_sel & step & (cnt_nxt == ccr_act_q);

    ccr_pre_d = (ccr_we & ~cfg.cap_sel) ? ccr_wdata : ccr_pre_q;

    ccr_act_d = ccr_act_q;
    if (cfg.cap_sel) begin
      if (cap_evt) ccr_act_d = cnt_q;
    end else if (ccr_we & ~cfg.pre_en) begin
      ccr_act_d = ccr_wdata;
    end else if (uev & cfg.pre_en) begin
      ccr_act_d = ccr_pre_q;
    end

    oc_d = oc_q;
    if (cmp_evt) begin
      case (cfg.mode)
        OC_SET:    oc_d = 1'b1;
        OC_CLR:    oc_d = 1'b0;
        OC_TOGGLE: oc_d = ~oc_q;
        default:   oc_d = oc_q;
      endcase
    end

    below = cnt_q < ccr_act_q;
    if (cfg.cap_sel) out = 1'b0;
    else begin
      case (cfg.mode)
        OC_PWM_LO: out = below;
        OC_PWM_HI: out = ~below;
        default:   out = oc_q;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1_q  <= 1'b0;
      pin_s2_q  <= 1'b0;
      pin_d_q   <= 1'b0;
      ecnt_q    <= '0;
      ccr_pre_q <= '0;
      ccr_act_q <= '0;
      oc_q      <= 1'b0;
    end else begin
      pin_s1_q  <= pin;
      pin_s2_q  <= pin_s1_q;
      pin_d_q   <= pin_s2_q;
      ecnt_q    <= ecnt_d;
      ccr_pre_q <= ccr_pre_d;
      ccr_act_q <= ccr_act_d;
      oc_q      <= oc_d;
    end
  end

endmodule

// File: rtl/cc_timer.sv
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CW  = 16,
  parameter int PW  = 4,
  parameter int NCH = 3,
  parameter int AW  = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  input  logic [NCH-1:0] ch_in,
  output logic [NCH-1:0] ch_out,
  output logic           irq
);

  localparam int FW = 1 + 2 * NCH;
  localparam int IW = 1 + NCH;

  logic           run_q, run_d, arpe_q, arpe_d, opm_q, opm_d;
  logic [PW-1:0]  psc_pre_q, psc_pre_d, psc_act;
  logic [CW-1:0]  arr_pre_q, arr_pre_d, arr_act_q, arr_act_d;
  logic [IW-1:0]  ien_q, ien_d;
  logic [FW-1:0]  flag_q, flag_d, flag_set, flag_clr;
  logic [CW-1:0]  rdata_q, rdata_d;
  ch_cfg_t        cfg_q [NCH];
  ch_cfg_t        cfg_d [NCH];
  logic [CW-1:0]  ccr_act [NCH];
  logic [NCH-1:0] ccr_we, cmp_evt, cap_evt;

  logic           wr_ctrl, wr_psc, wr_arr, wr_ien, wr_stat, cnt_we, ug;
  logic [CW-1:0]  cnt_q, cnt_nxt;
  logic           step, ovf, uev;

  assign bus_rdata = rdata_q;

  // bus decode
  always_comb begin
    wr_ctrl = bus_we & (bus_addr == AW'(ADDR_CTRL));
    wr_psc  = bus_we & (bus_addr == AW'(ADDR_PSC));
    wr_arr  = bus_we & (bus_addr == AW'(ADDR_ARR));
    wr_ien  = bus_we & (bus_addr == AW'(ADDR_IEN));
    wr_stat = bus_we & (bus_addr == AW'(ADDR_STAT));
    cnt_we  = bus_we & (bus_addr == AW'(ADDR_CNT));
    ug      = bus_we & (bus_addr == AW'(ADDR_EVGEN)) & bus_wdata[0];
    for (int i = 0; i < NCH; i++) begin
      ccr_we[i] = bus_we & (bus_addr == AW'(ADDR_CCR0 + i));
    end
  end

  cct_timebase #(.CW(CW), .PW(PW)) u_tb (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (run_q),
    .ug        (ug),
    .cnt_we    (cnt_we),
    .cnt_wdata (bus_wdata),
    .arr_act   (arr_act_q),
    .psc_pre   (psc_pre_q),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .psc_act   (psc_act),
    .step      (step),
    .ovf       (ovf),
    .uev       (uev)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cct_channel #(.CW(CW)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg       (cfg_q[g]),
      .ccr_we    (ccr_we[g]),
      .ccr_wdata (bus_wdata),
      .uev       (uev),
      .step      (step),
      .cnt_q     (cnt_q),
      .cnt_nxt   (cnt_nxt),
      .pin       (ch_in[g]),
      .ccr_act   (ccr_act[g]),
      .out       (ch_out[g]),
      .cmp_evt   (cmp_evt[g]),
      .cap_evt   (cap_evt[g])
    );
  end

  // control and shadow next state
  always_comb begin
    run_d  = run_q;
    arpe_d = arpe_q;
    opm_d  = opm_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[0];
      arpe_d = bus_wdata[1];
      opm_d  = bus_wdata[2];
    end
    if (ovf & opm_q) run_d = 1'b0;

    psc_pre_d = wr_psc ? bus_wdata[PW-1:0] : psc_pre_q;
    arr_pre_d = wr_arr ? bus_wdata : arr_pre_q;

    arr_act_d = arr_act_q;
    if (wr_arr & ~arpe_q)   arr_act_d = bus_wdata;
    else if (uev & arpe_q)  arr_act_d = arr_pre_q;

    ien_d = wr_ien ? bus_wdata[IW-1:0] : ien_q;

    for (int i = 0; i < NCH; i++) begin
      cfg_d[i] = (bus_we & (bus_addr == AW'(ADDR_CFG0 + i)))
                 ? ch_cfg_t'(bus_wdata[CFG_W-1:0]) : cfg_q[i];
    end
  end

  // flag next state
  always_comb begin
    flag_set    = '0;
    flag_set[0] = uev;
    for (int i = 0; i < NCH; i++) begin
      flag_set[1 + i]       = cap_evt[i] | cmp_evt[i];
      flag_set[1 + NCH + i] = cap_evt[i] & flag_q[1 + i];
    end
    flag_clr = wr_stat ? bus_wdata[FW-1:0] : '0;
    flag_d   = flag_set | (flag_q & ~flag_clr);
  end

  assign irq = |(flag_q[IW-1:0] & ien_q);

  // read mux
  always_comb begin
    rdata_d = '0;
    if (bus_addr == AW'(ADDR_CTRL))      rdata_d = CW'({opm_q, arpe_q, run_q});
    else if (bus_addr == AW'(ADDR_PSC))  rdata_d = CW'(psc_act);
    else if (bus_addr == AW'(ADDR_ARR))  rdata_d = arr_act_q;
    else if (bus_addr == AW'(ADDR_CNT))  rdata_d = cnt_q;
    else if (bus_addr == AW'(ADDR_IEN))  rdata_d = CW'(ien_q);
    else if (bus_addr == AW'(ADDR_STAT)) rdata_d = CW'(flag_q);
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == AW'(ADDR_CFG0 + i)) rdata_d = CW'(cfg_q[i]);
      if (bus_addr == AW'(ADDR_CCR0 + i)) rdata_d = ccr_act[i];
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      arpe_q    <= 1'b0;
      opm_q     <= 1'b0;
      psc_pre_q <= '0;
      arr_pre_q <= '1;
      arr_act_q <= '1;
      ien_q     <= '0;
      flag_q    <= '0;
      rdata_q   <= '0;
      for (int i = 0; i < NCH; i++) cfg_q[i] <= '0;
    end else begin
      run_q     <= run_d;
      arpe_q    <= arpe_d;
      opm_q     <= opm_d;
      psc_pre_q <= psc_pre_d;
      arr_pre_q <= arr_pre_d;
      arr_act_q <= arr_act_d;
      ien_q     <= ien_d;
      flag_q    <= flag_d;
      rdata_q   <= rdata_d;
      for (int i = 0; i < NCH; i++) cfg_q[i] <= cfg_d[i];
    end
  end

endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CW  = 16,
  parameter int NCH = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  cnt_q,
  input logic           cnt_we,
  input logic           ug,
  input logic           uif,
  input logic           run_q,
  input logic           opm_q,
  input logic [NCH-1:0] ccif,
  input logic [NCH-1:0] ovc
);

  assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q != $past(cnt_q)) && !$past(cnt_we) && !$past(ug))
      |-> ((cnt_q == $past(cnt_q) + 1'b1) || (cnt_q == '0)));

  assert_cnt_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run_q) && !$past(cnt_we) && !$past(ug)) |-> $stable(cnt_q));

  assert_uif_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uif) |-> ($past(ug) || (cnt_q == '0)));

  assert_opm_halt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && $past(opm_q) && ($past(cnt_q) != '0) && (cnt_q == '0)
      && !$past(cnt_we) && !$past(ug)) |-> !run_q);

  for (genvar g = 0; g < NCH; g++) begin : g_ovc
    assert_ovc_flag_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovc[g]) |-> $past(ccif[g]));
  end

endmodule

bind cc_timer cct_checker #(.CW(CW), .NCH(NCH)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cnt_q  (cnt_q),
  .cnt_we (cnt_we),
  .ug     (ug),
  .uif    (flag_q[0]),
  .run_q  (run_q),
  .opm_q  (opm_q),
  .ccif   (flag_q[NCH:1]),
  .ovc    (flag_q[2*NCH:NCH+1])
);

// File: tb/cc_timer_test.sv
`timescale 1ns/1ps
module cc_timer_test;

  localparam int A_CTRL = 0, A_EV = 1, A_PSC = 2, A_ARR = 3, A_CNT = 4;
  localparam int A_IEN = 5, A_STAT = 6, A_CFG = 8, A_CCR = 12;

  logic        clk, rst_n, bus_we, irq;
  logic [3:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic [2:0]  ch_in, ch_out;

  int n_chk, n_fail;
  logic [15:0] v;

  cc_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ch_in(ch_in),
    .ch_out(ch_out), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, int d);
    bus_we = 1'b1; bus_addr = a[3:0]; bus_wdata = d[15:0];
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] r);
    bus_addr = a[3:0];
    @(posedge clk); @(negedge clk);
    r = bus_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_high(int ch, int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      if (ch_out[ch]) h++;
      @(negedge clk);
    end
  endtask

  function automatic int exp_cnt(int j, int psc, int arr);
    return ((j + 1) >> psc) % (arr + 1);
  endfunction

  function automatic int exp_high(int c, int a, int p, bit inv);
    int lo;
    lo = (c > a + 1) ? a + 1 : c;
    return inv ? (a + 1 - lo) * p : lo * p;
  endfunction

  task automatic run_count(int psc, int arr, int j);
    wr(A_CTRL, 0);
    wr(A_ARR, arr);
    wr(A_PSC, psc);
    wr(A_EV, 1);
    wr(A_STAT, 16'h7F);
    wr(A_CTRL, 1);
    idle(j);
    wr(A_CTRL, 0);
    rd(A_CNT, v);
    chk("R2 prescaled count", v, exp_cnt(j, psc, arr));
    rd(A_STAT, v);
    chk("R3 update flag on wrap", v[0], (((j + 1) >> psc) > arr) ? 1 : 0);
  endtask

  task automatic pwm_case(int ch, int mode, int c, int a, int p);
    int h;
    wr(A_CTRL, 0);
    wr(A_CFG + ch, mode);
    wr(A_ARR, a);
    wr(A_PSC, 0);
    wr(A_CCR + ch, c);
    wr(A_EV, 1);
    wr(A_CTRL, 1);
    idle(1);
    count_high(ch, p * (a + 1), h);
    chk("R7 PWM duty", h, exp_high(c, a, p, mode == 5));
    wr(A_CTRL, 0);
  endtask

  task automatic pulse_pin(int ch, bit val);
    ch_in[ch] = val;
    idle(5);
  endtask

  initial begin
    #1_500_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int h, t;
    logic prev;
    n_chk = 0; n_fail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; ch_in = '0;
    idle(4);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 outputs", ch_out, 0);
    chk("R1 irq", irq, 0);
    rd(A_CNT, v);  chk("R1 counter", v, 0);
    rd(A_ARR, v);  chk("R1 reload", v, 16'hFFFF);
    rd(A_STAT, v); chk("R1 flags", v, 0);
    rd(A_PSC, v);  chk("R1 prescaler", v, 0);
    rd(A_CCR, v);  chk("R1 compare", v, 0);

    // R2 / R3 random counting
    for (int it = 0; it < 10; it++) begin
      run_count($urandom % 4, 5 + $urandom % 40, 10 + $urandom % 150);
    end
    run_count(10, 1000, 2999);
    run_count(0, 3, 3);

    // R4 prescaler buffering
    wr(A_CTRL, 0); wr(A_PSC, 0); wr(A_ARR, 3); wr(A_EV, 1);
    wr(A_PSC, 2);
    rd(A_PSC, v); chk("R4 code held before update", v, 0);
    wr(A_CTRL, 1); idle(10); wr(A_CTRL, 0);
    rd(A_PSC, v); chk("R4 code applied at overflow", v, 2);
    wr(A_PSC, 0); wr(A_EV, 1);
    rd(A_PSC, v); chk("R4 code applied by forced update", v, 0);

    // R5 reload and compare buffering
    wr(A_CTRL, 2); wr(A_ARR, 100);
    rd(A_ARR, v); chk("R5 buffered reload held", v, 3);
    wr(A_EV, 1);
    rd(A_ARR, v); chk("R5 buffered reload loaded", v, 100);
    wr(A_CTRL, 0); wr(A_ARR, 50);
    rd(A_ARR, v); chk("R5 direct reload", v, 50);
    wr(A_CFG, 4); wr(A_CCR, 3);
    rd(A_CCR, v); chk("R5 direct compare", v, 3);
    wr(A_CFG, 12); wr(A_CCR, 7);
    rd(A_CCR, v); chk("R5 buffered compare held", v, 3);
    wr(A_EV, 1);
    rd(A_CCR, v); chk("R5 buffered compare loaded", v, 7);

    // R6 forced update
    wr(A_CFG, 0); wr(A_CNT, 55); wr(A_STAT, 16'h7F);
    rd(A_CNT, v); chk("R6 counter written", v, 55);
    wr(A_EV, 1);
    rd(A_CNT, v); chk("R6 counter cleared", v, 0);
    rd(A_STAT, v); chk("R6 update flag", v[0], 1);

    // R7 PWM
    pwm_case(0, 4, 5, 19, 3);
    pwm_case(0, 4, 0, 9, 3);
    pwm_case(0, 4, 16, 15, 2);
    pwm_case(2, 5, 3, 9, 3);
    for (int it = 0; it < 3; it++) begin
      pwm_case(1, 4 + ($urandom % 2), $urandom % 30, 5 + $urandom % 20, 2);
    end
    for (int c = 0; c < 3; c++) wr(A_CFG + c, 0);

    // R8 output compare modes
    wr(A_ARR, 30); wr(A_PSC, 0);
    wr(A_CFG + 1, 1); wr(A_CCR + 1, 6); wr(A_EV, 1); wr(A_STAT, 16'h7F);
    chk("R8 set mode before match", ch_out[1], 0);
    wr(A_CTRL, 1); idle(10); wr(A_CTRL, 0);
    chk("R8 set on match", ch_out[1], 1);
    rd(A_STAT, v); chk("R8 compare flag", v[2], 1);
    wr(A_CFG + 1, 2); wr(A_EV, 1);
    wr(A_CTRL, 1); idle(10); wr(A_CTRL, 0);
    chk("R8 clear on match", ch_out[1], 0);
    wr(A_CFG + 1, 0); wr(A_EV, 1); wr(A_STAT, 16'h7F);
    wr(A_CTRL, 1); idle(10); wr(A_CTRL, 0);
    chk("R8 frozen holds", ch_out[1], 0);
    rd(A_STAT, v); chk("R8 frozen still flags", v[2], 1);
    wr(A_ARR, 7); wr(A_CFG + 2, 3); wr(A_CCR + 2, 2); wr(A_EV, 1);
    wr(A_CTRL, 1); idle(2);
    prev = ch_out[2]; t = 0;
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (ch_out[2] != prev) t++;
      prev = ch_out[2];
    end
    wr(A_CTRL, 0);
    chk("R8 toggle count over three periods", t, 3);
    wr(A_CFG + 2, 0);

    // R9 one-pulse
    wr(A_CFG + 1, 5); wr(A_CCR + 1, 4); wr(A_ARR, 12); wr(A_EV, 1);
    wr(A_CTRL, 5);
    count_high(1, 40, h);
    chk("R9 single pulse width", h, 9);
    rd(A_CTRL, v); chk("R9 run bit cleared", v[0], 0);
    rd(A_CNT, v); chk("R9 counter stopped at zero", v, 0);
    wr(A_CTRL, 0); wr(A_CFG + 1, 0);

    // R10 capture
    wr(A_CFG, 16); wr(A_CNT, 1234); wr(A_STAT, 16'h7F);
    pulse_pin(0, 1);
    rd(A_CCR, v); chk("R10 rising capture value", v, 1234);
    rd(A_STAT, v); chk("R10 capture flag", v[1], 1);
    wr(A_CFG, 48); wr(A_CNT, 500); wr(A_STAT, 16'h7F);
    pulse_pin(0, 0);
    rd(A_CCR, v); chk("R10 falling capture value", v, 500);
    wr(A_CNT, 600); wr(A_STAT, 16'h7F);
    pulse_pin(0, 1);
    rd(A_CCR, v); chk("R10 wrong edge ignored", v, 500);
    rd(A_STAT, v); chk("R10 no flag on wrong edge", v[1], 0);
    wr(A_CCR, 9999);
    rd(A_CCR, v); chk("R10 write ignored in capture", v, 500);
    pulse_pin(0, 0);

    // R11 capture divider (every 4th edge)
    wr(A_CFG + 2, 16 + (2 << 6)); wr(A_STAT, 16'h7F);
    for (int k = 1; k <= 4; k++) begin
      wr(A_CNT, 100 * k);
      pulse_pin(2, 1);
      pulse_pin(2, 0);
      rd(A_STAT, v);
      chk("R11 divided capture flag", v[3], (k == 4) ? 1 : 0);
    end
    rd(A_CCR + 2, v); chk("R11 divided capture value", v, 400);

    // R12 overcapture
    wr(A_CFG, 16); wr(A_STAT, 16'h7F);
    wr(A_CNT, 11); pulse_pin(0, 1); pulse_pin(0, 0);
    rd(A_STAT, v); chk("R12 no overcapture on first", v[4], 0);
    wr(A_CNT, 22); pulse_pin(0, 1); pulse_pin(0, 0);
    rd(A_STAT, v); chk("R12 overcapture flag", v[4], 1);
    rd(A_CCR, v); chk("R12 newest value kept", v, 22);
    wr(A_CFG, 0);

    // R13 interrupt
    wr(A_STAT, 16'h7F); wr(A_IEN, 1);
    chk("R13 irq idle", irq, 0);
    wr(A_EV, 1);
    chk("R13 irq on update", irq, 1);
    wr(A_STAT, 0);
    chk("R13 zero write keeps flag", irq, 1);
    wr(A_STAT, 1);
    chk("R13 one write clears flag", irq, 0);
    wr(A_IEN, 0); wr(A_EV, 1);
    chk("R13 masked flag no irq", irq, 0);
    rd(A_STAT, v); chk("R13 masked flag still set", v[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule